// File: doc/BRIEF.md
# Synchronous Burst Flash Read Sequencer

This block turns single read requests from an internal requester into read bursts on a synchronous burst-mode flash device. The requester offers a start address with a valid/ready handshake. The sequencer then selects the device and pulses the address-valid strobe. It waits out the access time and returns one data beat per clock, each with a valid pulse and a last flag.

A burst runs in one of two modes. It can stop after a programmed beat count of 1, 2, 4 or 8. It can also stream until the requester withdraws its request. The device's WAIT pin is read either as a stall, which inserts idle cycles, or as an early end of the burst. Extra sampling latency can be added when the clock feedback path is in use. The address-valid and burst-advance strobes can launch on the rising edge, or half a cycle later from the falling edge. All settings are captured when a burst starts.

Top module: `bflash_rd_seq`

## Requirements
- R1: After reset, chip select, address-valid and burst-advance (all active low) read 1, rsp_valid and cfg_err read 0, and req_ready reads 1.
- R2: In fixed-length mode (cfg_fixed_len=1), burst-length code 0, 1, 2 or 3 yields 1, 2, 4 or 8 returned beats, and rsp_last is set only on the final one.
- R3: A burst-length code with bit 2 set yields a single beat, and cfg_err reads 1 from that burst's start until the next burst starts with a legal code.
- R4: In streaming mode (cfg_fixed_len=0), beats continue until a beat is taken while req_valid is 0; that beat carries rsp_last.
- R5: With cfg_wait_term=0, a data cycle with fl_wait=1 takes no beat and does not assert the burst-advance strobe.
- R6: With cfg_wait_term=1, a data cycle with fl_wait=1 takes that cycle's data as the final beat, with both rsp_last and rsp_term set.
- R7: Counting the address cycle as cycle 0, the first beat is fl_data of cycle 1+INIT_CYC+L, where L is cfg_lat. Each later non-stalled cycle supplies the next beat, and a beat appears on rsp_data one cycle after its sample cycle.
- R8: With cfg_fb_en=0, L is taken as 0 whatever cfg_lat holds.
- R9: Address-valid is low for exactly one cycle per burst and is never low together with burst-advance. With cfg_early=1 both strobes change at the rising edge. With cfg_early=0 they change at the following falling edge.
- R10: req_ready is 1 only while idle. Chip select stays low from the address cycle through the last data cycle, then high for at least one cycle before the next burst.
- R11: Changes on the configuration inputs during a burst do not affect that burst.
- R12: rsp_term is set only together with rsp_valid and rsp_last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len_code | input | 3 | Burst-length code (0..3 legal, bit 2 set reserved) |
| cfg_fixed_len | input | 1 | 1: stop after beat count, 0: stream until request drops |
| cfg_wait_term | input | 1 | 0: WAIT stalls, 1: WAIT ends the burst |
| cfg_lat | input | 4 | Extra sampling latency in cycles |
| cfg_fb_en | input | 1 | Clock feedback in use; 0 forces latency to 0 |
| cfg_early | input | 1 | 1: strobes on rising edge, 0: half-cycle delayed |
| req_valid | input | 1 | Request valid; in streaming mode also keeps the burst alive |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_addr | input | AW | Burst start address |
| rsp_valid | output | 1 | Data beat valid |
| rsp_data | output | DW | Returned data beat |
| rsp_last | output | 1 | Final beat of the burst |
| rsp_term | output | 1 | Burst ended by WAIT |
| cfg_err | output | 1 | Reserved burst-length code used in current burst |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_addr | output | AW | Flash address |
| fl_adv_n | output | 1 | Address-valid strobe, active low |
| fl_baa_n | output | 1 | Burst-advance strobe, active low |
| fl_wait | input | 1 | Device WAIT |
| fl_data | input | DW | Device read data |

## Verification
A wrong sequencer state shows at once as a beat count that is off, or as a last flag on the wrong beat. It can also show as a chip-select window whose length does not match the sample cycles. All of these are visible within the burst where the fault occurs. A latency or counter error shifts every beat's data tag, because the bench gives each cycle a unique data value, so the first returned beat already reveals it. A strobe-phase error shows within half a cycle of the address cycle, when the address-valid level is read on each side of the falling edge.

// File: rtl/bflash_pkg.sv
package bflash_pkg;

  localparam int LAT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_LAT,
    ST_DATA,
    ST_END
  } seq_state_e;

  typedef struct packed {
    logic [2:0]       beats_m1;
    logic             fixed_len;
    logic             wait_term;
    logic [LAT_W-1:0] lat;
    logic             early;
    logic             bad_len;
  } burst_cfg_t;

  // Encoded length code to beat count minus one; reserved codes give one beat.
  function automatic logic [2:0] beats_m1_of(input logic [2:0] code);
    logic [3:0] n;
    n = 4'd1 << code[1:0];
    if (code[2]) return 3'd0;
    return 3'(n - 4'd1);
  endfunction

endpackage

// File: rtl/bflash_cfg_hold.sv
module bflash_cfg_hold
  import bflash_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [2:0]       len_code,
  input  logic             fixed_len,
  input  logic             wait_term,
  input  logic [LAT_W-1:0] lat,
  input  logic             fb_en,
  input  logic             early,
  output burst_cfg_t       cfg_q
);

  burst_cfg_t cfg_d;

  always_comb begin
    cfg_d.beats_m1  = beats_m1_of(len_code);
    cfg_d.fixed_len = fixed_len;
    cfg_d.wait_term = wait_term;
    cfg_d.lat       = fb_en ? lat : '0;
    cfg_d.early     = early;
    cfg_d.bad_len   = len_code[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.beats_m1  <= 3'd0;
      cfg_q.fixed_len <= 1'b1;
      cfg_q.wait_term <= 1'b0;
      cfg_q.lat       <= '0;
      cfg_q.early     <= 1'b0;
      cfg_q.bad_len   <= 1'b0;
    end else if (load) begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/bflash_seq_fsm.sv
module bflash_seq_fsm
  import bflash_pkg::*;
#(
  parameter int AW       = 24,
  parameter int DW       = 16,
  parameter int INIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       beats_m1,
  input  logic             fixed_len,
  input  logic             wait_term,
  input  logic [LAT_W-1:0] lat,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  output logic             start,
  output logic             req_ready,
  input  logic             fl_wait,
  input  logic [DW-1:0]    fl_data,
  output seq_state_e       st_q,
  output logic             cs_n,
  output logic [AW-1:0]    addr_q,
  output logic             adv_rise_n,
  output logic             baa_rise_n,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             rsp_last,
  output logic             rsp_term
);

  localparam int CNT_W = $clog2(INIT_CYC + (1 << LAT_W) + 1);
  localparam logic [CNT_W-1:0] INIT_M1 = CNT_W'(INIT_CYC - 1);

  seq_state_e       st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [2:0]       beat_q, beat_d;
  logic             beat_en;
  logic             in_data, stall, term_hit, take, fix_end, cont_end, fin;

  // Beat decisions in the data phase
  always_comb begin
    in_data  = (st_q == ST_DATA);
    stall    = in_data & fl_wait & ~wait_term;
    term_hit = in_data & fl_wait & wait_term;
    take     = in_data & ~stall;
    fix_end  = fixed_len & (beat_q == beats_m1);
    cont_end = ~fixed_len & ~req_valid;
    fin      = take & (fix_end | cont_end | term_hit);
    start    = (st_q == ST_IDLE) & req_valid;
    req_ready = (st_q == ST_IDLE);
  end

  // Next state and counters
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    beat_d  = beat_q;
    beat_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_ADDR;
      ST_ADDR: begin
        st_d    = ST_LAT;
        cnt_d   = INIT_M1 + CNT_W'(lat);
        cnt_en  = 1'b1;
        beat_d  = 3'd0;
        beat_en = 1'b1;
      end
      ST_LAT: begin
        if (cnt_q == '0) begin
          st_d = ST_DATA;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_DATA: begin
        if (take) begin
          beat_d  = beat_q + 3'd1;
          beat_en = 1'b1;
        end
        if (fin) st_d = ST_END;
      end
      ST_END:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= 3'd0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (start) begin
      addr_q <= req_addr;
    end
  end

  // Response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      rsp_term  <= 1'b0;
    end else begin
      rsp_valid <= take;
      rsp_last  <= fin;
      rsp_term  <= term_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data <= '0;
    end else if (take) begin
      rsp_data <= fl_data;
    end
  end

  always_comb begin
    cs_n       = ~((st_q == ST_ADDR) | (st_q == ST_LAT) | (st_q == ST_DATA));
    adv_rise_n = ~(st_q == ST_ADDR);
    baa_rise_n = ~take;
  end

endmodule

// File: rtl/bflash_strobe_phase.sv
module bflash_strobe_phase #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         early,
  input  logic [N-1:0] rise_n,
  output logic [N-1:0] out_n
);

  logic [N-1:0] fall_q;

  for (genvar i = 0; i < N; i++) begin : g_lane
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fall_q[i] <= 1'b1;
      end else begin
        fall_q[i] <= rise_n[i];
      end
    end

    always_comb out_n[i] = early ? rise_n[i] : fall_q[i];
  end

endmodule

// File: rtl/bflash_rd_seq.sv
module bflash_rd_seq
  import bflash_pkg::*;
#(
  parameter int AW       = 24,
  parameter int DW       = 16,
  parameter int INIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_len_code,
  input  logic             cfg_fixed_len,
  input  logic             cfg_wait_term,
  input  logic [LAT_W-1:0] cfg_lat,
  input  logic             cfg_fb_en,
  input  logic             cfg_early,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             rsp_last,
  output logic             rsp_term,
  output logic             cfg_err,
  output logic             fl_cs_n,
  output logic [AW-1:0]    fl_addr,
  output logic             fl_adv_n,
  output logic             fl_baa_n,
  input  logic             fl_wait,
  input  logic [DW-1:0]    fl_data
);

  logic [1:0] rst_pipe;
  logic       rst_q;
  logic       start;
  logic       adv_rise_n, baa_rise_n;
  logic [1:0] strobe_n;
  burst_cfg_t cfg_q;
  seq_state_e st_q;

  // Reset asserts at once and releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_q = rst_pipe[1];

  bflash_cfg_hold u_cfg (
    .clk      (clk),
    .rst_n    (rst_q),
    .load     (start),
    .len_code (cfg_len_code),
    .fixed_len(cfg_fixed_len),
    .wait_term(cfg_wait_term),
    .lat      (cfg_lat),
    .fb_en    (cfg_fb_en),
    .early    (cfg_early),
    .cfg_q    (cfg_q)
  );

  bflash_seq_fsm #(
    .AW      (AW),
    .DW      (DW),
    .INIT_CYC(INIT_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_q),
    .beats_m1  (cfg_q.beats_m1),
    .fixed_len (cfg_q.fixed_len),
    .wait_term (cfg_q.wait_term),
    .lat       (cfg_q.lat),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .start     (start),
    .req_ready (req_ready),
    .fl_wait   (fl_wait),
    .fl_data   (fl_data),
    .st_q      (st_q),
    .cs_n      (fl_cs_n),
    .addr_q    (fl_addr),
    .adv_rise_n(adv_rise_n),
    .baa_rise_n(baa_rise_n),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last),
    .rsp_term  (rsp_term)
  );

  bflash_strobe_phase #(.N(2)) u_strobe (
    .clk   (clk),
    .rst_n (rst_q),
    .early (cfg_q.early),
    .rise_n({baa_rise_n, adv_rise_n}),
    .out_n (strobe_n)
  );

  assign fl_adv_n = strobe_n[0];
  assign fl_baa_n = strobe_n[1];
  assign cfg_err  = cfg_q.bad_len;

endmodule

// File: rtl/bflash_rd_seq_chk.sv
module bflash_rd_seq_chk
  import bflash_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input seq_state_e st,
  input logic       wait_term,
  input logic       fl_wait,
  input logic       req_ready,
  input logic       fl_cs_n,
  input logic       fl_adv_n,
  input logic       fl_baa_n,
  input logic       rsp_valid,
  input logic       rsp_last,
  input logic       rsp_term
);

  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> fl_cs_n);

  // R12
  term_with_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_term |-> (rsp_valid && rsp_last));

  // R9
  adv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_adv_n |=> fl_adv_n);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_adv_n && !fl_baa_n));

  // R5
  stall_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && fl_wait && !wait_term) |=> !rsp_valid);

  // R6
  term_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && fl_wait && wait_term) |=> (rsp_valid && rsp_last && rsp_term));

endmodule

bind bflash_rd_seq bflash_rd_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .st       (st_q),
  .wait_term(cfg_q.wait_term),
  .fl_wait  (fl_wait),
  .req_ready(req_ready),
  .fl_cs_n  (fl_cs_n),
  .fl_adv_n (fl_adv_n),
  .fl_baa_n (fl_baa_n),
  .rsp_valid(rsp_valid),
  .rsp_last (rsp_last),
  .rsp_term (rsp_term)
);

// File: tb/bflash_rd_seq_bench.sv
module bflash_rd_seq_bench;

  localparam int AW       = 24;
  localparam int DW       = 16;
  localparam int INIT_CYC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [2:0]    cfg_len_code;
  logic          cfg_fixed_len, cfg_wait_term, cfg_fb_en, cfg_early;
  logic [3:0]    cfg_lat;
  logic          req_valid, req_ready;
  logic [AW-1:0] req_addr;
  logic          rsp_valid, rsp_last, rsp_term, cfg_err;
  logic [DW-1:0] rsp_data;
  logic          fl_cs_n, fl_adv_n, fl_baa_n, fl_wait;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_data;

  int checks = 0;
  int errors = 0;

  logic [DW+1:0] exp_q[$];
  string         req_q[$];

  always #2 clk = ~clk;

  bflash_rd_seq #(.AW(AW), .DW(DW), .INIT_CYC(INIT_CYC)) u_bflash_rd_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_len_code(cfg_len_code), .cfg_fixed_len(cfg_fixed_len),
    .cfg_wait_term(cfg_wait_term), .cfg_lat(cfg_lat), .cfg_fb_en(cfg_fb_en),
    .cfg_early(cfg_early), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_last(rsp_last), .rsp_term(rsp_term), .cfg_err(cfg_err),
    .fl_cs_n(fl_cs_n), .fl_addr(fl_addr), .fl_adv_n(fl_adv_n),
    .fl_baa_n(fl_baa_n), .fl_wait(fl_wait), .fl_data(fl_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: pop and compare each returned beat
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R12", "unexpected beat", {rsp_data, rsp_last, rsp_term}, 0);
        end else begin
          logic [DW+1:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          chk({rsp_data, rsp_last, rsp_term} == e, r, "beat data/last/term",
              {rsp_data, rsp_last, rsp_term}, e);
        end
      end
    end
  end

  // Driver: predict the beats, start the burst, then act as the flash per cycle
  task automatic run_burst(input logic [2:0] code, input bit fixed, input bit term,
                           input logic [3:0] lat, input bit fb, input bit early,
                           input int drop, input logic [31:0] wmask,
                           input logic [7:0] tag, input bit chg, input string req);
    int  lcyc, idx, beats, nb, last_idx, n_cs, n_baa;
    bit  l, t, w;
    lcyc  = INIT_CYC + (fb ? int'(lat) : 0);
    nb    = code[2] ? 1 : (1 << code[1:0]);
    idx   = 1 + lcyc;
    beats = 0;
    while (1) begin
      w = wmask[idx];
      if (w && !term) begin
        idx++;
        continue;
      end
      t = term && w;
      l = t || (fixed ? (beats == nb - 1) : (idx >= drop));
      exp_q.push_back({tag, 8'(idx), l, t});
      req_q.push_back(req);
      beats++;
      if (l) break;
      idx++;
    end
    last_idx = idx;

    cfg_len_code  = code;
    cfg_fixed_len = fixed;
    cfg_wait_term = term;
    cfg_lat       = lat;
    cfg_fb_en     = fb;
    cfg_early     = early;
    req_addr      = {tag, 16'h0100};
    req_valid     = 1'b1;
    while (1) begin
      @(posedge clk);
      #1;
      if (!fl_cs_n) break;
    end
    idx   = 0;
    n_cs  = 0;
    n_baa = 0;
    while (!fl_cs_n) begin
      fl_data   = {tag, 8'(idx)};
      fl_wait   = wmask[idx];
      req_valid = (idx < drop);
      n_cs++;
      if (!fl_baa_n) n_baa++;
      if (idx == 0) begin
        chk(req_ready == 1'b0, "R10", "req_ready in burst", req_ready, 0);
        chk(fl_addr == req_addr, "R10", "address out", fl_addr, req_addr);
        if (early) begin
          chk(fl_adv_n == 1'b0, "R9", "early adv after rise", fl_adv_n, 0);
        end else begin
          chk(fl_adv_n == 1'b1, "R9", "delayed adv after rise", fl_adv_n, 1);
          #2;
          chk(fl_adv_n == 1'b0, "R9", "delayed adv after fall", fl_adv_n, 0);
        end
        // R11: configuration moves after the start; the burst must ignore it
        if (chg) begin
          cfg_len_code  = 3'd3;
          cfg_fixed_len = ~fixed;
          cfg_early     = ~early;
        end
      end
      @(posedge clk);
      #1;
      idx++;
    end
    if (!fl_baa_n) n_baa++;
    fl_wait   = 1'b0;
    req_valid = 1'b0;
    chk(n_cs == last_idx + 1, req, "chip select cycles (R10)", n_cs, last_idx + 1);
    repeat (3) @(posedge clk);
    #1;
    chk(n_baa == beats, req, "burst-advance pulses (R5)", n_baa, beats);
    chk(exp_q.size() == 0, req, "beats outstanding", exp_q.size(), 0);
    chk(cfg_err == code[2], "R3", "cfg_err", cfg_err, code[2]);
    chk(fl_cs_n == 1'b1 && req_ready == 1'b1, "R10", "idle after burst",
        {fl_cs_n, req_ready}, 2'b11);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    cfg_len_code  = 3'd0;
    cfg_fixed_len = 1'b1;
    cfg_wait_term = 1'b0;
    cfg_lat       = 4'd0;
    cfg_fb_en     = 1'b1;
    cfg_early     = 1'b1;
    req_valid     = 1'b0;
    req_addr      = '0;
    fl_wait       = 1'b0;
    fl_data       = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(fl_cs_n && fl_adv_n && fl_baa_n, "R1", "strobes idle",
        {fl_cs_n, fl_adv_n, fl_baa_n}, 3'b111);
    chk(!rsp_valid && !cfg_err, "R1", "rsp_valid/cfg_err", {rsp_valid, cfg_err}, 0);
    chk(req_ready, "R1", "req_ready", req_ready, 1);

    // R2: each legal length code, early strobes
    for (int c = 0; c < 4; c++) begin
      run_burst(3'(c), 1'b1, 1'b0, 4'd0, 1'b1, 1'b1, 1, 32'h0, 8'(8'h10 + c), 1'b0, "R2");
    end
    // R3: reserved code gives one beat and flags an error, cleared by next burst
    run_burst(3'd5, 1'b1, 1'b0, 4'd0, 1'b1, 1'b1, 1, 32'h0, 8'h20, 1'b0, "R3");
    run_burst(3'd0, 1'b1, 1'b0, 4'd0, 1'b1, 1'b1, 1, 32'h0, 8'h21, 1'b0, "R3");
    // R4: streaming mode, request drops in cycle 6
    run_burst(3'd0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 6, 32'h0, 8'h30, 1'b0, "R4");
    // R4: streaming with a stall on the drop cycle
    run_burst(3'd0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 5, 32'h0000_0060, 8'h31, 1'b0, "R4");
    // R5: stalls in cycles 4 and 5 of a 4-beat burst
    run_burst(3'd2, 1'b1, 1'b0, 4'd0, 1'b1, 1'b1, 1, 32'h0000_0030, 8'h40, 1'b0, "R5");
    // R6: WAIT ends an 8-beat burst in cycle 5
    run_burst(3'd3, 1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 1, 32'h0000_0020, 8'h50, 1'b0, "R6");
    // R6: WAIT on the very first data cycle
    run_burst(3'd2, 1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 1, 32'h0000_0008, 8'h51, 1'b0, "R6");
    // R7: extra latency of 3 with feedback enabled
    run_burst(3'd1, 1'b1, 1'b0, 4'd3, 1'b1, 1'b1, 1, 32'h0, 8'h60, 1'b0, "R7");
    // R8: latency field ignored without feedback
    run_burst(3'd1, 1'b1, 1'b0, 4'd5, 1'b0, 1'b1, 1, 32'h0, 8'h70, 1'b0, "R8");
    // R9: half-cycle delayed strobes with a stall
    run_burst(3'd2, 1'b1, 1'b0, 4'd1, 1'b1, 1'b0, 1, 32'h0000_0040, 8'h80, 1'b0, "R9");
    // R11: configuration changed mid-burst
    run_burst(3'd1, 1'b1, 1'b0, 4'd0, 1'b1, 1'b1, 1, 32'h0, 8'h90, 1'b1, "R11");
    // R12: terminate in delayed mode, last/term together
    run_burst(3'd3, 1'b1, 1'b1, 4'd2, 1'b1, 1'b0, 1, 32'h0000_0100, 8'hA0, 1'b0, "R12");
    finish_run();
  end

endmodule